// File: doc/BRIEF.md
# Timer Channel Counter with Selectable Count Clock

This block is one channel of a general-purpose timer. An up-counter, 16 bits wide by default, advances once for each rising edge of a count clock. The count clock is chosen from eight sources. Five are prescaled internal timer clocks. The other three are external clock lines. Block-level routing controls feed each external line from either a dedicated input pin or the output of a neighbouring channel, so channels can be chained to make longer counts.

All edge detection runs in the system clock domain. The chosen source passes through a two-flop synchroniser, and each rising transition produces a one-cycle count enable. Every source must therefore toggle more slowly than half the system clock rate.

Counting is gated by start and stop commands. A hardware or software trigger requests a reset of the count. The reset is held pending and takes effect on the next valid count edge, not at once. A sticky overflow flag records each wrap of the counter and clears when software reads the status.

Top module: `tcChannel`

## Requirements
- R1: After reset the count is zero, the overflow flag is clear, and counting is stopped: source edges leave the count at zero until a start command arrives.
- R2: While running, the count rises by exactly one per rising edge of the selected source. A source held high gives only one increment.
- R3: Clock-select codes 0 to 4 pick internal clocks 0 to 4, and codes 5, 6 and 7 pick external lines 0, 1 and 2. Edges on unselected sources leave the count unchanged.
- R4: Route bit n set to 0 feeds external line n from pin input n. Route bit n set to 1 feeds it from chain input n, and the other input of that pair is ignored.
- R5: A start command enables counting and a stop command disables it. If both arrive in the same cycle, the stop wins. While stopped, the count holds its value.
- R6: An increment from all-ones wraps the count to zero and sets the overflow flag.
- R7: The overflow flag stays set until a status read clears it. An overflow that occurs in the same cycle as the read leaves the flag set.
- R8: A hardware or software trigger pulse does not change the count. The next valid count edge loads zero instead of incrementing. A trigger that lands on an all-ones count does not set the overflow flag.
- R9: After the selected source goes high, the new count appears at the output following the third rising system clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| intClk | input | NUM_INT | Prescaled internal timer clocks |
| extPin | input | NUM_EXT | Dedicated external clock pins |
| chainIn | input | NUM_EXT | Outputs of neighbouring channels, used for chaining |
| xcRoute | input | NUM_EXT | Per-line routing: 0 selects the pin, 1 selects the chain input |
| clkSel | input | SEL_W | Count clock source select |
| startCmd | input | 1 | One-cycle command that enables counting |
| stopCmd | input | 1 | One-cycle command that disables counting |
| swTrig | input | 1 | Software trigger pulse |
| hwTrig | input | 1 | Hardware trigger pulse |
| statusRd | input | 1 | Status read strobe, clears the overflow flag |
| countVal | output | CNT_W | Live counter value |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
If the synchroniser depth or the edge detector is wrong, the count changes one cycle too early or too late after the source rises, or changes twice for one pulse. Both faults show up on the first pulse after start. A trigger that is not held as pending, or that clears the count at once, shows as a zero count before any source edge, or as a count that keeps climbing after the next edge. A wrong overflow priority shows only on a status read that coincides with a wrap, so the bench lines these two events up to the exact cycle.

// File: rtl/tcPkg.sv
package tcPkg;
  typedef struct packed {
    logic countEn;   // one valid count-clock edge this cycle
    logic loadZero;  // replace the increment with a load of zero
  } ctrlStrobes_t;
endpackage

// File: rtl/tcChanCtrl.sv
module tcChanCtrl
  import tcPkg::*;
#(
  parameter int NUM_INT = 5,
  parameter int NUM_EXT = 3,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_INT-1:0] intClk,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [NUM_EXT-1:0] chainIn,
  input  logic [NUM_EXT-1:0] xcRoute,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic               startCmd,
  input  logic               stopCmd,
  input  logic               swTrig,
  input  logic               hwTrig,
  output ctrlStrobes_t       strobes
);
  localparam int NUM_SRC = NUM_INT + NUM_EXT;
  localparam int PAD_SRC = 1 << SEL_W;

  logic [NUM_SRC-1:0] srcVec;
  logic [PAD_SRC-1:0] srcPad;
  logic selSrc;
  logic [2:0] syncSh;
  logic rise, running, pending, trigNow, countEn;

  assign srcVec[NUM_INT-1:0] = intClk;
  for (genvar g = 0; g < NUM_EXT; g++) begin : gXcRoute
    assign srcVec[NUM_INT+g] = xcRoute[g] ? chainIn[g] : extPin[g];
  end

  always_comb begin
    srcPad = '0;
    srcPad[NUM_SRC-1:0] = srcVec;
  end
  assign selSrc = srcPad[clkSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncSh <= '0;
    else       syncSh <= {syncSh[1:0], selSrc};
  end
  assign rise = syncSh[1] & ~syncSh[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         running <= 1'b0;
    else if (stopCmd)  running <= 1'b0;
    else if (startCmd) running <= 1'b1;
  end

  assign trigNow = swTrig | hwTrig;
  assign countEn = rise & running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pending <= 1'b0;
    else if (countEn) pending <= 1'b0;
    else if (trigNow) pending <= 1'b1;
  end

  assign strobes.countEn  = countEn;
  assign strobes.loadZero = countEn & (pending | trigNow);

  // R5: a stop command leaves the channel stopped, even alongside a start
  a_r5_stop_wins: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> !running);
  // R8: a trigger without an edge is remembered for the next edge
  a_r8_trig_held: assert property (@(posedge clk) disable iff (!rstN)
    (trigNow && !countEn) |=> pending);
  // R8: an edge consumes any pending trigger
  a_r8_pending_consumed: assert property (@(posedge clk) disable iff (!rstN)
    countEn |=> !pending);
  // R2: two enables never come back to back from one synchronised source
  a_r2_single_enable: assert property (@(posedge clk) disable iff (!rstN)
    countEn |=> !countEn);
endmodule

// File: rtl/tcChanDatapath.sv
module tcChanDatapath
  import tcPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             statusRd,
  output logic [CNT_W-1:0] countVal,
  output logic             ovfFlag
);
  logic wrap;

  assign wrap = strobes.countEn & ~strobes.loadZero & (&countVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 countVal <= '0;
    else if (strobes.loadZero) countVal <= '0;
    else if (strobes.countEn)  countVal <= countVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ovfFlag <= 1'b0;
    else if (wrap)     ovfFlag <= 1'b1;
    else if (statusRd) ovfFlag <= 1'b0;
  end

  // R2: a plain enable adds exactly one
  a_r2_increment: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEn && !strobes.loadZero) |=> countVal == $past(countVal) + 1'b1);
  // R5: without an enable the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.countEn |=> $stable(countVal));
  // R8: a triggered edge gives zero
  a_r8_load_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadZero |=> countVal == '0);
  // R6: an enable on all-ones raises the flag
  a_r6_wrap_sets: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.countEn && !strobes.loadZero && (&countVal)) |=> ovfFlag);
  // R7: a read with no edge clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !strobes.countEn) |=> !ovfFlag);
  // R8: a triggered edge never raises the flag by itself
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadZero && !ovfFlag) |=> !ovfFlag);
endmodule

// File: rtl/tcChannel.sv
module tcChannel
  import tcPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_INT = 5,
  parameter int NUM_EXT = 3,
  parameter int SEL_W   = $clog2(NUM_INT + NUM_EXT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_INT-1:0] intClk,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [NUM_EXT-1:0] chainIn,
  input  logic [NUM_EXT-1:0] xcRoute,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic               startCmd,
  input  logic               stopCmd,
  input  logic               swTrig,
  input  logic               hwTrig,
  input  logic               statusRd,
  output logic [CNT_W-1:0]   countVal,
  output logic               ovfFlag
);
  ctrlStrobes_t strobes;

  tcChanCtrl #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .intClk(intClk), .extPin(extPin),
    .chainIn(chainIn), .xcRoute(xcRoute), .clkSel(clkSel),
    .startCmd(startCmd), .stopCmd(stopCmd), .swTrig(swTrig),
    .hwTrig(hwTrig), .strobes(strobes)
  );

  tcChanDatapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusRd(statusRd),
    .countVal(countVal), .ovfFlag(ovfFlag)
  );
endmodule

// File: tb/tcChannel_test.sv
module tcChannel_test;
  localparam int W = 10;
  localparam logic [W-1:0] MAXV = '1;

  logic clk = 1'b0, rstN = 1'b0;
  logic [4:0] intClk = '0;
  logic [2:0] extPin = '0, chainIn = '0, xcRoute = '0;
  logic [2:0] clkSel = '0;
  logic startCmd = 0, stopCmd = 0, swTrig = 0, hwTrig = 0, statusRd = 0;
  logic [W-1:0] countVal;
  logic ovfFlag;
  int nChecks = 0, nFails = 0;
  logic [W-1:0] expCnt;

  always #2 clk = ~clk;

  tcChannel #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .intClk(intClk), .extPin(extPin),
    .chainIn(chainIn), .xcRoute(xcRoute), .clkSel(clkSel),
    .startCmd(startCmd), .stopCmd(stopCmd), .swTrig(swTrig),
    .hwTrig(hwTrig), .statusRd(statusRd), .countVal(countVal), .ovfFlag(ovfFlag)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // grp 0 = internal, 1 = pin, 2 = chain
  task automatic setSrc(input int grp, input int idx, input logic v);
    case (grp)
      0: intClk[idx] = v;
      1: extPin[idx] = v;
      default: chainIn[idx] = v;
    endcase
  endtask

  task automatic pulse(input int grp, input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      setSrc(grp, idx, 1'b1); cyc(3);
      setSrc(grp, idx, 1'b0); cyc(3);
    end
  endtask

  task automatic strobe(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  task automatic testReset();
    check("R1 count", countVal, '0);
    check("R1 ovf", W'(ovfFlag), '0);
    pulse(0, 0, 3);
    check("R1 stopped", countVal, '0);
    strobe(startCmd);
  endtask

  task automatic testLatency();
    intClk[0] = 1'b1;
    cyc(2);
    check("R9 not yet", countVal, '0);
    cyc(1);
    check("R9 third edge", countVal, 1);
    cyc(20);
    check("R2 level held", countVal, 1);
    intClk[0] = 1'b0; cyc(3);
    expCnt = 1;
  endtask

  task automatic testSelect();
    for (int s = 0; s < 5; s++) begin
      clkSel = 3'(s); cyc(3);
      pulse(0, s, 2);
      pulse(0, (s + 1) % 5, 1);
      pulse(1, s % 3, 1);
      expCnt += 2;
      check("R3 internal select", countVal, expCnt);
    end
  endtask

  task automatic testRoute();
    for (int x = 0; x < 3; x++) begin
      clkSel = 3'(5 + x); xcRoute[x] = 1'b0; cyc(3);
      pulse(1, x, 3); pulse(2, x, 2); pulse(0, 0, 1);
      expCnt += 3;
      check("R4 pin route", countVal, expCnt);
      xcRoute[x] = 1'b1; cyc(3);
      pulse(2, x, 2); pulse(1, x, 4);
      expCnt += 2;
      check("R4 chain route", countVal, expCnt);
    end
    clkSel = 3'd0; xcRoute = '0; cyc(3);
  endtask

  task automatic testGate();
    strobe(stopCmd);
    pulse(0, 0, 3);
    check("R5 stopped holds", countVal, expCnt);
    startCmd = 1; stopCmd = 1; cyc(1); startCmd = 0; stopCmd = 0;
    pulse(0, 0, 2);
    check("R5 stop wins", countVal, expCnt);
    strobe(startCmd);
    pulse(0, 0, 2); expCnt += 2;
    check("R5 restart", countVal, expCnt);
  endtask

  task automatic testTrigger();
    strobe(hwTrig); cyc(5);
    check("R8 hw not immediate", countVal, expCnt);
    pulse(0, 0, 1);
    check("R8 hw zero at edge", countVal, '0);
    pulse(0, 0, 2);
    check("R8 counts on after", countVal, 2);
    strobe(swTrig); cyc(5);
    check("R8 sw not immediate", countVal, 2);
    pulse(0, 0, 1);
    check("R8 sw zero at edge", countVal, '0);
    expCnt = 0;
  endtask

  task automatic testOverflow();
    pulse(0, 0, int'(MAXV));
    check("R6 at max", countVal, MAXV);
    check("R6 no flag yet", W'(ovfFlag), '0);
    pulse(0, 0, 1);
    check("R6 wrap", countVal, '0);
    check("R6 flag set", W'(ovfFlag), 1);
    cyc(10);
    check("R7 sticky", W'(ovfFlag), 1);
    strobe(statusRd);
    check("R7 read clears", W'(ovfFlag), '0);
    // wrap again with a read lined up on the counting cycle
    pulse(0, 0, int'(MAXV));
    intClk[0] = 1'b1; cyc(2);
    statusRd = 1'b1; cyc(1); statusRd = 1'b0;
    check("R7 set beats read", W'(ovfFlag), 1);
    check("R6 wrap again", countVal, '0);
    cyc(2); intClk[0] = 1'b0; cyc(3);
    strobe(statusRd);
    // trigger on an all-ones count
    pulse(0, 0, int'(MAXV));
    strobe(hwTrig);
    pulse(0, 0, 1);
    check("R8 trig at max zero", countVal, '0);
    check("R8 trig no overflow", W'(ovfFlag), '0);
  endtask

  initial begin
    #(4 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    cyc(3); rstN = 1'b1; cyc(2);
    testReset();
    testLatency();
    testSelect();
    testRoute();
    testGate();
    testTrigger();
    testOverflow();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule